// File: doc/BRIEF.md
# Backlight Brightness PWM Generator

This block drives a panel backlight with a pulse-width-modulated brightness signal derived from the system clock. A programmable pre-divider sets how often a free-running 256-step counter advances. A programmable width value sets how many of those 256 steps the output spends at its active level. The result is a brightness ratio of width/256 at a repetition rate of clock/(256·(N+1)).

For flicker-free video, the block can restart its period on each rising edge of the horizontal gate, which keeps the PWM phase locked to the video line. The output polarity can be inverted. Two register-style inputs hold the configuration. Width and polarity are sampled only at period boundaries, so a software write never produces a runt pulse. When disabled, the block parks its output at the inactive level.

Top module: `bright_pwm`

## Requirements
- R1: While `rst_n` is low, `pwm_out` is 0. The internal reset is released two clock edges after `rst_n` rises, and counting starts from step 0 with pre-divider count 0.
- R2: `cfg_ctrl` bit 0 is enable, bit 1 is invert, bit 2 is sync enable, and bits [10:3] hold the pre-divider value N. With N applied, the step counter advances once every N+1 clocks.
- R3: A period lasts 256 steps. Before inversion, the output is high while the step count is less than the latched width. Width 0 gives a constant low. Width 255 gives high for 255 of every 256 steps.
- R4: When the latched invert bit is 1, the output is the complement of the R3 waveform.
- R5: While enable is 0, the step counter and pre-divider are held at 0 and `pwm_out` equals the invert bit, one clock after it is applied.
- R6: With enable and sync both set, a rising edge of `hgate` (high now, low on the previous clock) clears the step counter and the pre-divider on the next clock. With sync clear, `hgate` has no effect on the output.
- R7: A new `cfg_width` or invert value reaches the output only at a period start. A period starts at the wrap from step 255, at a sync restart, or on any clock while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hgate | input | 1 | Horizontal video gate, used for period resync |
| cfg_ctrl | input | 11 | {pre-divider[7:0], sync, invert, enable} |
| cfg_width | input | 8 | Active-level step count per period |
| pwm_out | output | 1 | Brightness PWM output |

## Verification
The bench builds the block with its default 8-bit pre-divider and 8-bit step counter. A full 256-step period is therefore observable with small divider ratios. Sync pulses spaced shorter than a period show that every restart lands mid-period. The pre-divider settings used are 0 to 3, which keep several complete periods within a short run. This is enough to count exact high-step totals for widths 255 and 64, and to see width changes deferred to the next wrap.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
  // bit positions inside the control register input
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_INV_BIT  = 1;
  localparam int unsigned CTRL_SYNC_BIT = 2;
  localparam int unsigned CTRL_DIV_LSB  = 3;
endpackage

// File: rtl/bpwm_rst_sync.sv
module bpwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/bpwm_prediv.sv
module bpwm_prediv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] ratio,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             at_end;

  // >= so a ratio lowered mid-count ends the current slot at once
  assign at_end = (cnt_q >= ratio);
  assign tick   = run & ~restart & at_end;

  always_comb begin
    if (!run || restart || at_end) cnt_d = '0;
    else                           cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!srst_n)
    restart |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/bpwm_steps.sv
module bpwm_steps #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  output logic [CNT_W-1:0] step,
  output logic             load
);
  localparam logic [CNT_W-1:0] STEP_LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] step_q;
  logic [CNT_W-1:0] step_d;
  logic             adv_en;

  assign adv_en = run & tick;
  assign load   = ~run | restart | (adv_en & (step_q == STEP_LAST));

  always_comb begin
    if (!run || restart) step_d = '0;
    else if (adv_en)     step_d = step_q + CNT_W'(1);
    else                 step_d = step_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) step_q <= '0;
    else         step_q <= step_d;
  end

  assign step = step_q;

  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (run && !restart && !tick) |=> $stable(step_q)); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    !run |=> (step_q == '0)); // R5
endmodule

// File: rtl/bpwm_shape.sv
module bpwm_shape #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] width,
  input  logic             invert,
  input  logic [CNT_W-1:0] step,
  output logic             pwm
);
  logic [CNT_W-1:0] wid_q, wid_d;
  logic             pol_q, pol_d;
  logic             run_q;

  always_comb begin
    wid_d = load ? width  : wid_q;
    pol_d = load ? invert : pol_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wid_q <= '0;
      pol_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      wid_q <= wid_d;
      pol_q <= pol_d;
      run_q <= run;
    end
  end

  assign pwm = pol_q ^ (run_q & (step < wid_q));

  AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !load |=> ($stable(wid_q) && $stable(pol_q))); // R7

  AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!srst_n)
    (run_q && wid_q == '0) |-> (pwm == pol_q)); // R3
endmodule

// File: rtl/bright_pwm.sv
module bright_pwm #(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned RST_STAGES = 2,
  localparam int unsigned CTRL_W    = DIV_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hgate,
  input  logic [CTRL_W-1:0] cfg_ctrl,
  input  logic [CNT_W-1:0]  cfg_width,
  output logic              pwm_out
);
  import bpwm_pkg::*;

  logic             srst_n;
  logic             en, inv, sync_en;
  logic [DIV_W-1:0] ratio;
  logic             hg_q;
  logic             sync_hit;
  logic             tick;
  logic             load;
  logic [CNT_W-1:0] step;

  assign en      = cfg_ctrl[CTRL_EN_BIT];
  assign inv     = cfg_ctrl[CTRL_INV_BIT];
  assign sync_en = cfg_ctrl[CTRL_SYNC_BIT];
  assign ratio   = cfg_ctrl[CTRL_DIV_LSB +: DIV_W];

  bpwm_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) hg_q <= 1'b0;
    else         hg_q <= hgate;
  end

  assign sync_hit = en & sync_en & hgate & ~hg_q;

  bpwm_prediv #(.DIV_W(DIV_W)) i_prediv (
    .clk(clk), .srst_n(srst_n), .run(en), .restart(sync_hit),
    .ratio(ratio), .tick(tick)
  );

  bpwm_steps #(.CNT_W(CNT_W)) i_steps (
    .clk(clk), .srst_n(srst_n), .run(en), .restart(sync_hit),
    .tick(tick), .step(step), .load(load)
  );

  bpwm_shape #(.CNT_W(CNT_W)) i_shape (
    .clk(clk), .srst_n(srst_n), .run(en), .load(load),
    .width(cfg_width), .invert(inv), .step(step), .pwm(pwm_out)
  );

  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!srst_n)
    sync_hit |=> (step == '0)); // R6

  AST_NO_SYNC_LOAD: assert property (@(posedge clk) disable iff (!srst_n)
    (en && !sync_en && tick && step != '1) |-> !load); // R6
endmodule

// File: tb/test_bright_pwm.sv
module test_bright_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hgate = 1'b0;
  logic [10:0] cfg_ctrl = '0;
  logic [7:0]  cfg_width = '0;
  logic        pwm_out;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  bright_pwm i_bright_pwm (
    .clk(clk), .rst_n(rst_n), .hgate(hgate),
    .cfg_ctrl(cfg_ctrl), .cfg_width(cfg_width), .pwm_out(pwm_out)
  );

  // behavioural reference
  int  m_div, m_step, m_wid;
  bit  m_pol, m_en_q, m_hg, s1, s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; m_div = 0; m_step = 0; m_wid = 0;
      m_pol = 0; m_en_q = 0; m_hg = 0;
    end else begin
      if (!s2) begin
        m_div = 0; m_step = 0; m_wid = 0; m_pol = 0; m_en_q = 0; m_hg = 0;
      end else begin
        bit en, sy, tk, ld, rise;
        int n;
        en = cfg_ctrl[0];
        n = int'(cfg_ctrl[10:3]);
        rise = hgate && !m_hg;
        sy = en && cfg_ctrl[2] && rise;
        tk = en && !sy && (m_div >= n);
        ld = !en || sy || (tk && m_step == 255);
        m_hg = hgate;
        m_en_q = en;
        if (!en || sy || tk) m_div = 0; else m_div = m_div + 1;
        if (!en || sy) m_step = 0; else if (tk) m_step = (m_step + 1) % 256;
        if (ld) begin m_wid = int'(cfg_width); m_pol = cfg_ctrl[1]; end
      end
      s2 = s1; s1 = 1;
    end
  end

  function automatic bit model_out();
    return m_pol ^ (m_en_q && (m_step < m_wid));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle compare against the reference
  always @(negedge clk) begin
    if (rst_n && !done) chk(pwm_out == model_out(), cur_req, pwm_out, model_out());
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(bit en, bit inv, bit sy, int div, int wid);
    cfg_ctrl  = {8'(div), sy, inv, en};
    cfg_width = 8'(wid);
  endtask

  task automatic count_high(int n, int exp, string req);
    int hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    chk(hi == exp, req, hi, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    cyc(5);
    chk(pwm_out == 1'b0, "R1", pwm_out, 0);
    rst_n = 1'b1;
    cyc(4);
    chk(pwm_out == 1'b0, "R1", pwm_out, 0);

    // R3: full width, no divider: 255 high per 256
    cur_req = "R3";
    set_cfg(1, 0, 0, 0, 255);
    cyc(600);
    count_high(256, 255, "R3");

    // R3 and R7: width 0 written mid-period
    cur_req = "R7";
    set_cfg(1, 0, 0, 0, 0);
    cyc(300);
    cur_req = "R3";
    count_high(256, 0, "R3");

    // R2: divide by two, width 64
    cur_req = "R2";
    set_cfg(1, 0, 0, 1, 64);
    cyc(1200);
    count_high(512, 128, "R2");

    // R4: inverted, divide by three, width 100
    cur_req = "R4";
    set_cfg(1, 1, 0, 2, 100);
    cyc(1600);
    count_high(768, 768 - 300, "R4");

    // R6: sync restarts every 300 clocks
    cur_req = "R6";
    set_cfg(1, 0, 1, 3, 40);
    for (int k = 0; k < 8; k++) begin
      hgate = 1'b1; cyc(2); hgate = 1'b0; cyc(298);
    end
    // R6: sync disabled, hgate ignored
    set_cfg(1, 0, 0, 3, 40);
    for (int k = 0; k < 5; k++) begin
      hgate = 1'b1; cyc(2); hgate = 1'b0; cyc(198);
    end

    // R5: disabled output follows invert bit
    cur_req = "R5";
    set_cfg(0, 1, 0, 3, 40);
    cyc(20);
    chk(pwm_out == 1'b1, "R5", pwm_out, 1);
    set_cfg(0, 0, 0, 3, 200);
    cyc(20);
    chk(pwm_out == 1'b0, "R5", pwm_out, 0);

    // R7: width change mid-period waits for wrap
    cur_req = "R7";
    set_cfg(1, 0, 0, 0, 128);
    cyc(300);
    set_cfg(1, 1, 0, 0, 16);
    cyc(2);
    chk(pwm_out == model_out(), "R7", pwm_out, model_out());
    cyc(600);

    // R1: reset mid-run
    cur_req = "R1";
    @(negedge clk);
    rst_n = 1'b0;
    cyc(3);
    chk(pwm_out == 1'b0, "R1", pwm_out, 0);
    rst_n = 1'b1;
    cyc(300);

    finish_run();
  end
endmodule